// File: doc/BRIEF.md
# Serial Audio Converter Sample Controller

This block moves 8-bit audio samples between a serial analog-to-digital converter, an external serial-in/parallel-out register that feeds a parallel digital-to-analog converter, and a hub-side parallel sample port. All timing comes from one system clock. A divider produces a bit clock, and a frame state machine produces an active-low converter select and an active-low DAC load strobe. A frame lasts ten bit periods. It holds one idle bit period, one leading bit that the ADC sends as a dummy, and eight data bit periods. The controller samples ADC data on bit clock rising edges. It changes its own outbound serial bit only when the bit clock falls, so the external shift register, which shifts on the rising edge, sees stable data.

The frame state machine has four states:
- `FS_GAP`: select high. The outbound word is latched here.
- `FS_LEAD`: select low. The dummy ADC bit arrives and the first outbound bit is presented.
- `FS_DATA`: seven bit periods, counted by an index.
- `FS_LAST`: the final ADC bit arrives and the load strobe is low.

The transitions are `FS_GAP→FS_LEAD`, `FS_LEAD→FS_DATA`, `FS_DATA→FS_DATA` while the index is below its limit, `FS_DATA→FS_LAST` at the limit, and `FS_LAST→FS_GAP`. Every transition happens at the end of a bit period.

In normal mode, each captured sample is presented to the hub with a one-cycle valid pulse. The outbound word is taken from the hub once per frame. In diagnostic mode the captured sample does not go to the hub. It becomes the next outbound word instead, which loops the converter path back on itself.

Top module: `audio_serdes_ctrl`

## Requirements
- R1: The bit clock has a period of exactly BIT_DIV system clocks. It is low for the first BIT_DIV/2 of them and high for the rest.
- R2: Each frame is SAMPLE_W+2 bit periods long. The select is high for exactly one bit period and low for SAMPLE_W+1 bit periods, and it changes only when the bit clock falls.
- R3: The bit received in the first low-select bit period is discarded. The next SAMPLE_W bits, sampled at bit clock rising edges, form the captured word, most significant bit first.
- R4: In normal mode every frame yields exactly one `rx_valid` pulse, one system clock wide, and `rx_data` carries that frame's captured word.
- R5: The outbound word is latched at the start of the idle bit period, with a one-cycle `tx_take` pulse. Later changes of `tx_data` do not affect the frame in progress.
- R6: `dac_sdi` presents the outbound word most significant bit first, in the SAMPLE_W bit periods that follow the idle period, and changes only when the bit clock falls.
- R7: `dac_load_n` is low for exactly the last bit period of the frame, and only while select is low. A register that shifts on the rising edge and is read at the strobe's falling edge then holds the frame's outbound word.
- R8: While `diag_en` is high during a frame, `rx_valid` stays low and `rx_data` holds its value. The word latched at that frame's end is that frame's captured sample, not `tx_data`.
- R9: During reset the bit clock, `rx_valid`, `tx_take`, `dac_sdi` and `rx_data` are 0, and select and load strobe are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| diag_en | input | 1 | Diagnostic loopback enable |
| adc_sdo | input | 1 | Serial data from the ADC |
| adc_cs_n | output | 1 | Active-low converter select, one pulse pattern per frame |
| bit_clk | output | 1 | Serial bit clock for both converter paths |
| dac_sdi | output | 1 | Serial outbound data to the DAC shift register |
| dac_load_n | output | 1 | Active-low DAC update strobe |
| tx_data | input | SAMPLE_W | Outbound sample from the hub |
| tx_take | output | 1 | One-cycle pulse when `tx_data` is latched |
| rx_data | output | SAMPLE_W | Last captured inbound sample for the hub |
| rx_valid | output | 1 | One-cycle pulse with a new `rx_data` |

## Verification
The bench builds the block with SAMPLE_W = 8 and BIT_DIV = 4, so that a frame lasts only forty system clocks. With frames that short, every one of the 256 inbound codes and every one of the 256 outbound codes passes through its own frame. Behavioural models of the ADC and of the shift register with DAC latch follow the bit clock. A closing run of frames switches diagnostic mode on and off between frames, which exercises loopback of the previous capture, suppression of the hub pulse, and the return to normal delivery.

// File: rtl/audio_serdes_pkg.sv
package audio_serdes_pkg;
    typedef enum logic [1:0] {
        FS_GAP  = 2'd0,
        FS_LEAD = 2'd1,
        FS_DATA = 2'd2,
        FS_LAST = 2'd3
    } frame_state_e;
endpackage

// File: rtl/ser_bit_timer.sv
module ser_bit_timer #(
    parameter int BIT_DIV = 500
) (
    input  logic clk,
    input  logic rst_n,
    output logic bclk,
    output logic bit_end,
    output logic bit_rise
);
    localparam int HALF = BIT_DIV / 2;
    localparam int CW   = (BIT_DIV > 2) ? $clog2(BIT_DIV) : 1;

    logic [CW-1:0] div_q;

    assign bit_end  = (div_q == CW'(BIT_DIV - 1));
    assign bit_rise = (div_q == CW'(HALF - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
            bclk  <= 1'b0;
        end else begin
            div_q <= bit_end ? '0 : div_q + CW'(1);
            if (bit_rise)
                bclk <= 1'b1;
            else if (bit_end)
                bclk <= 1'b0;
        end
    end

    // R1: a bit period always starts with the clock low
    p_low_after_end_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bit_end) |-> !bclk);
endmodule

// File: rtl/ser_frame_fsm.sv
module ser_frame_fsm
    import audio_serdes_pkg::*;
#(
    parameter int SAMPLE_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_end,
    input  logic bit_rise,
    output logic cs_n,
    output logic load_n,
    output logic frame_go,
    output logic shift_go,
    output logic sample_go,
    output logic last_go
);
    localparam int CW       = $clog2(SAMPLE_W);
    localparam int LAST_IDX = SAMPLE_W - 2;

    frame_state_e st, st_nxt;
    logic [CW-1:0] idx, idx_nxt;

    always_comb begin
        st_nxt  = st;
        idx_nxt = idx;
        unique case (st)
            FS_GAP:  st_nxt = FS_LEAD;
            FS_LEAD: begin
                st_nxt  = FS_DATA;
                idx_nxt = '0;
            end
            FS_DATA: begin
                if (idx == CW'(LAST_IDX))
                    st_nxt = FS_LAST;
                else
                    idx_nxt = idx + CW'(1);
            end
            FS_LAST: st_nxt = FS_GAP;
            default: st_nxt = FS_GAP;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= FS_GAP;
            idx <= '0;
        end else if (bit_end) begin
            st  <= st_nxt;
            idx <= idx_nxt;
        end
    end

    // registered pin outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n   <= 1'b1;
            load_n <= 1'b1;
        end else if (bit_end) begin
            cs_n   <= (st_nxt == FS_GAP);
            load_n <= (st_nxt != FS_LAST);
        end
    end

    assign frame_go  = bit_end && (st == FS_LAST);
    assign shift_go  = bit_end && ((st_nxt == FS_LEAD) || (st_nxt == FS_DATA));
    assign sample_go = bit_rise && ((st == FS_DATA) || (st == FS_LAST));
    assign last_go   = bit_rise && (st == FS_LAST);

    // R7: the DAC strobe only falls inside a selected frame
    p_load_in_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n |-> !cs_n);
    // R2: select rises only when the strobe period closes
    p_gap_after_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> $rose(load_n));
endmodule

// File: rtl/ser_adc_capture.sv
module ser_adc_capture #(
    parameter int SAMPLE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sample_go,
    input  logic                last_go,
    input  logic                sdo,
    output logic [SAMPLE_W-1:0] word,
    output logic                done
);
    logic [SAMPLE_W-1:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh   <= '0;
            word <= '0;
            done <= 1'b0;
        end else begin
            done <= last_go;
            if (sample_go)
                sh <= {sh[SAMPLE_W-2:0], sdo};
            if (last_go)
                word <= {sh[SAMPLE_W-2:0], sdo};
        end
    end
endmodule

// File: rtl/ser_dac_tx.sv
module ser_dac_tx #(
    parameter int SAMPLE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_go,
    input  logic                shift_go,
    input  logic                bit_end,
    input  logic [SAMPLE_W-1:0] src,
    output logic                sdi,
    output logic                take
);
    logic [SAMPLE_W-1:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh   <= '0;
            sdi  <= 1'b0;
            take <= 1'b0;
        end else begin
            take <= frame_go;
            if (frame_go) begin
                sh  <= src;
                sdi <= 1'b0;
            end else if (shift_go) begin
                sdi <= sh[SAMPLE_W-1];
                sh  <= {sh[SAMPLE_W-2:0], 1'b0};
            end else if (bit_end) begin
                sdi <= 1'b0;
            end
        end
    end

    // R5: the latch pulse never lasts beyond one cycle
    p_take_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !take);
endmodule

// File: rtl/audio_serdes_ctrl.sv
module audio_serdes_ctrl #(
    parameter int SAMPLE_W = 8,
    parameter int BIT_DIV  = 500
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                diag_en,
    input  logic                adc_sdo,
    output logic                adc_cs_n,
    output logic                bit_clk,
    output logic                dac_sdi,
    output logic                dac_load_n,
    input  logic [SAMPLE_W-1:0] tx_data,
    output logic                tx_take,
    output logic [SAMPLE_W-1:0] rx_data,
    output logic                rx_valid
);
    logic bit_end, bit_rise;
    logic frame_go, shift_go, sample_go, last_go;
    logic cap_done;
    logic [SAMPLE_W-1:0] cap_word, tx_src;

    ser_bit_timer #(.BIT_DIV(BIT_DIV)) u_timer (
        .clk(clk), .rst_n(rst_n), .bclk(bit_clk),
        .bit_end(bit_end), .bit_rise(bit_rise)
    );

    ser_frame_fsm #(.SAMPLE_W(SAMPLE_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .bit_end(bit_end), .bit_rise(bit_rise),
        .cs_n(adc_cs_n), .load_n(dac_load_n), .frame_go(frame_go),
        .shift_go(shift_go), .sample_go(sample_go), .last_go(last_go)
    );

    ser_adc_capture #(.SAMPLE_W(SAMPLE_W)) u_adc (
        .clk(clk), .rst_n(rst_n), .sample_go(sample_go), .last_go(last_go),
        .sdo(adc_sdo), .word(cap_word), .done(cap_done)
    );

    assign tx_src = diag_en ? cap_word : tx_data;

    ser_dac_tx #(.SAMPLE_W(SAMPLE_W)) u_dac (
        .clk(clk), .rst_n(rst_n), .frame_go(frame_go), .shift_go(shift_go),
        .bit_end(bit_end), .src(tx_src), .sdi(dac_sdi), .take(tx_take)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= cap_done && !diag_en;
            if (cap_done && !diag_en)
                rx_data <= cap_word;
        end
    end

    // R4: hub pulse is one cycle wide
    p_valid_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);
    // R8: hub word is frozen while loopback stays on
    p_diag_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (diag_en && $past(diag_en)) |-> $stable(rx_data));
    // R2: select moves only with a falling bit clock
    p_cs_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(adc_cs_n) |-> $fell(bit_clk));
    // R6: outbound serial bit moves only with a falling bit clock
    p_sdi_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(dac_sdi) |-> $fell(bit_clk));
endmodule

// File: tb/sim_audio_serdes_ctrl.sv
`timescale 1ns/1ps
module sim_audio_serdes_ctrl;
    localparam int W    = 8;
    localparam int DIV  = 4;
    localparam int HALF = DIV / 2;
    localparam int NFR  = 276;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic diag_en = 1'b0;
    logic adc_sdo = 1'b0;
    logic [W-1:0] tx_data;
    logic adc_cs_n, bit_clk, dac_sdi, dac_load_n, tx_take, rx_valid;
    logic [W-1:0] rx_data;

    always #10 clk = ~clk;

    audio_serdes_ctrl #(.SAMPLE_W(W), .BIT_DIV(DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .diag_en(diag_en), .adc_sdo(adc_sdo),
        .adc_cs_n(adc_cs_n), .bit_clk(bit_clk), .dac_sdi(dac_sdi),
        .dac_load_n(dac_load_n), .tx_data(tx_data), .tx_take(tx_take),
        .rx_data(rx_data), .rx_valid(rx_valid)
    );

    int n_vec = 0, n_err = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int adc_word(input int f);
        return (f < 256) ? f : ((f * 53 + 7) % 256);
    endfunction

    function automatic int tx_word(input int k);
        return (k * 37 + 11) % 256;
    endfunction

    function automatic bit diag_plan(input int f);
        return (f >= 256) && (f < 270) && (f != 262);
    endfunction

    // monitor / behavioural converter models state
    int cyc = 0, fidx = -1, k = 0, ktake = 0, pulses = 0;
    int last_rise = -1, cs_fall_c = -1, cs_rise_c = -1, load_fall_c = -1;
    int adc_cur = 0, exp_dac = 0, last_rx = 0;
    bit frame_diag = 0;
    logic p_bclk = 0, p_cs = 1, p_load = 1, p_sdi = 0;
    logic [W-1:0] dsr = '0, dac_out = '0;

    initial tx_data = W'(tx_word(0));

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            cyc++;
            // R1: bit clock shape
            if (bit_clk && !p_bclk) begin
                if (last_rise >= 0) chk(cyc - last_rise == DIV, "R1 period", cyc - last_rise, DIV);
                last_rise = cyc;
                dsr = {dsr[W-2:0], dac_sdi};
            end
            if (!bit_clk && p_bclk)
                chk(cyc - last_rise == HALF, "R1 high time", cyc - last_rise, HALF);
            // R6: serial outbound bit changes only at bit clock fall
            if (dac_sdi !== p_sdi)
                chk(!bit_clk && p_bclk, "R6 sdi edge", int'(bit_clk), 0);
            // R7: strobe
            if (!dac_load_n && p_load) begin
                load_fall_c = cyc;
                dac_out = dsr;
                chk(!adc_cs_n, "R7 strobe in frame", int'(adc_cs_n), 0);
                chk(dac_out == W'(exp_dac), "R6 R7 dac word", int'(dac_out), exp_dac);
            end
            if (dac_load_n && !p_load) begin
                chk(cyc - load_fall_c == DIV, "R7 strobe width", cyc - load_fall_c, DIV);
                chk(adc_cs_n, "R7 strobe ends frame", int'(adc_cs_n), 1);
            end
            // R5 / R8: outbound latch
            if (tx_take) begin
                exp_dac = diag_en ? adc_cur : int'(tx_data);
                ktake++;
                tx_data = W'(tx_word(ktake));
            end
            // R4 / R3: hub delivery
            if (rx_valid) begin
                pulses++;
                chk(!frame_diag, "R8 no pulse in diag", 1, 0);
                chk(rx_data == W'(adc_cur), "R3 R4 captured word", int'(rx_data), adc_cur);
                last_rx = int'(rx_data);
            end
            // R2: select timing and frame bookkeeping; ADC model
            if (adc_cs_n && !p_cs) begin
                cs_rise_c = cyc;
                chk(cyc - cs_fall_c == (W + 1) * DIV, "R2 select low", cyc - cs_fall_c, (W + 1) * DIV);
            end
            if (adc_cs_n) begin
                k = 0;
                adc_sdo = 1'b0;
            end else if (p_cs) begin
                if (fidx >= 0) begin
                    chk(cyc - cs_rise_c == DIV, "R2 select high", cyc - cs_rise_c, DIV);
                    chk(pulses == (frame_diag ? 0 : 1), "R4 R8 pulses per frame", pulses, frame_diag ? 0 : 1);
                    if (frame_diag) chk(int'(rx_data) == last_rx, "R8 hub word held", int'(rx_data), last_rx);
                end
                cs_fall_c = cyc;
                pulses = 0;
                fidx++;
                if (fidx >= NFR) finished = 1;
                adc_cur = adc_word(fidx);
                frame_diag = diag_plan(fidx);
                diag_en = frame_diag;
                k = 0;
                adc_sdo = 1'b0;   // R3 dummy leading bit
            end else if (!bit_clk && p_bclk) begin
                k++;
                adc_sdo = (k >= 1 && k <= W) ? adc_cur[W - k] : 1'b0;
            end
            p_bclk = bit_clk;
            p_cs = adc_cs_n;
            p_load = dac_load_n;
            p_sdi = dac_sdi;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(bit_clk == 1'b0, "R9 bit clock", int'(bit_clk), 0);
        chk(adc_cs_n == 1'b1, "R9 select", int'(adc_cs_n), 1);
        chk(dac_load_n == 1'b1, "R9 strobe", int'(dac_load_n), 1);
        chk(dac_sdi == 1'b0, "R9 sdi", int'(dac_sdi), 0);
        chk(rx_valid == 1'b0, "R9 valid", int'(rx_valid), 0);
        chk(tx_take == 1'b0, "R9 take", int'(tx_take), 0);
        chk(rx_data == '0, "R9 rx word", int'(rx_data), 0);
        rst_n = 1'b1;
        wait (finished);
        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_vec++;
            n_err++;
            $display("FAIL watchdog expired at frame %0d", fidx);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
            $finish;
        end
    end
endmodule